// File: doc/BRIEF.md
# Subgraph Dispatch Target Table

This block sits between the fetch and decode stages of an in-order core. When fetch presents the special call opcode that marks an accelerator subgraph, the block looks up the fetch address in a small direct-mapped table. Each table entry holds a tag, the expected call target, a count of input operands, up to six source register numbers and a configuration index.

On a hit, the call is not taken. The PC falls through to the next word, so no taken-branch bubble appears. The block then streams the subgraph's inputs to the accelerator, two register reads per cycle. It holds fetch stalled until the final pair has been sent. On a miss, the instruction becomes an ordinary branch-and-link: it redirects to the call target and writes the current PC to the link register.

A fill port writes whole entries. Software or a profiler uses it to install, replace or invalidate subgraph mappings.

Top module: `subgraph_dispatch`

## Requirements
- R1: After reset, every entry is invalid, no operand beat is emitted and stall_o is low, so the first special call misses.
- R2: A lookup uses fetch_pc_i[5:2] as entry index and fetch_pc_i[31:6] as tag. It hits only when the entry is valid, the tag matches, and the stored target equals fetch_tgt_i.
- R3: An accepted special call that misses asserts redirect_o and link_we_o in the same cycle, with next_pc_o = fetch_tgt_i and link_val_o = fetch_pc_i.
- R4: An accepted special call that hits keeps redirect_o and link_we_o low, with next_pc_o = fetch_pc_i + 4. Its first operand beat follows in the next cycle with pair number 0.
- R5: An instruction that is not the special opcode keeps redirect_o and link_we_o low, gives next_pc_o = fetch_pc_i + 4, and causes no beat and no stall.
- R6: A hit emits one beat per consecutive cycle, ceil(n/2) beats with at least one, where n is the stored count and values above 6 are treated as 6. Beat k has opnd_pair_o = k and drives register 2k on port A and register 2k+1 on port B. A lane whose position is n or more drives address 0 and data 0.
- R7: opnd_last_o is high on the final beat only. opnd_cfg_o carries the entry's configuration index on every beat.
- R8: stall_o is high during every beat except the final one. While stall_o is high, the fetch inputs are ignored and the same instruction is taken again once stall_o drops.
- R9: A fill write takes effect at the next clock edge. A lookup in the same cycle as a write to its entry still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch presents an instruction |
| fetch_special_i | input | 1 | Instruction is the subgraph call opcode |
| fetch_pc_i | input | 32 | Address of the fetched instruction |
| fetch_tgt_i | input | 32 | Call target decoded from the instruction |
| next_pc_o | output | 32 | Next fetch address |
| redirect_o | output | 1 | Control transfers to next_pc_o as a taken call |
| link_we_o | output | 1 | Write link register |
| link_val_o | output | 32 | Value for the link register |
| stall_o | output | 1 | Hold fetch |
| rd_addr_a_o | output | 5 | Register read address, port A |
| rd_addr_b_o | output | 5 | Register read address, port B |
| rd_data_a_i | input | 32 | Register read data, port A |
| rd_data_b_i | input | 32 | Register read data, port B |
| opnd_valid_o | output | 1 | Operand beat to accelerator |
| opnd_pair_o | output | 2 | Pair number of the beat |
| opnd_a_o | output | 32 | Even-position operand |
| opnd_b_o | output | 32 | Odd-position operand |
| opnd_last_o | output | 1 | Final beat of the subgraph |
| opnd_cfg_o | output | 4 | Configuration cache index |
| fill_en_i | input | 1 | Write an entry |
| fill_idx_i | input | 4 | Entry to write |
| fill_live_i | input | 1 | Valid bit written |
| fill_tag_i | input | 26 | Tag written |
| fill_tgt_i | input | 32 | Call target written |
| fill_cnt_i | input | 3 | Input count written |
| fill_regs_i | input | 30 | Six register numbers, position i in bits [5i+4:5i] |
| fill_cfg_i | input | 4 | Configuration index written |

## Verification
The hardest case to reach is a second special call that arrives while the operand gather of a previous hit is still stalling fetch. That call must be held and must not start a new gather. The bench gets there by issuing a call right behind a six-input hit, and the driver keeps the instruction on the fetch inputs until stall_o falls. The next hardest case is a fill that lands in the same cycle as a lookup of the same entry. The bench drives both together and expects a miss, then a hit on the retry.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int SGD_ENTRIES = 16;
  localparam int SGD_IDX_W   = $clog2(SGD_ENTRIES);
  localparam int SGD_PC_W    = 32;
  localparam int SGD_TAG_W   = SGD_PC_W - 2 - SGD_IDX_W;
  localparam int SGD_MAX_IN  = 6;
  localparam int SGD_REG_W   = 5;
  localparam int SGD_CNT_W   = 3;
  localparam int SGD_CFG_W   = 4;
  localparam int SGD_PAIR_W  = $clog2((SGD_MAX_IN + 1) / 2);
  localparam int SGD_REGS_W  = SGD_MAX_IN * SGD_REG_W;

  typedef struct packed {
    logic                  live;
    logic [SGD_TAG_W-1:0]  tag;
    logic [SGD_PC_W-1:0]   tgt;
    logic [SGD_CNT_W-1:0]  cnt;
    logic [SGD_REGS_W-1:0] regs;
    logic [SGD_CFG_W-1:0]  cfg;
  } sgd_entry_t;
endpackage

// File: rtl/sgd_table.sv
module sgd_table
  import sgd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [SGD_IDX_W-1:0] wr_idx_i,
  input  sgd_entry_t           wr_entry_i,
  input  logic [SGD_IDX_W-1:0] rd_idx_i,
  output sgd_entry_t           rd_entry_o
);
  sgd_entry_t mem_q [SGD_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SGD_ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_entry_i;
    end
  end

  // read sees pre-write contents in a write cycle
  assign rd_entry_o = mem_q[rd_idx_i];
endmodule

// File: rtl/sgd_seq.sv
module sgd_seq
  import sgd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [SGD_CNT_W-1:0]  cnt_i,
  input  logic [SGD_REGS_W-1:0] regs_i,
  input  logic [SGD_CFG_W-1:0]  cfg_i,
  output logic [SGD_REG_W-1:0]  rd_addr_a_o,
  output logic [SGD_REG_W-1:0]  rd_addr_b_o,
  input  logic [SGD_PC_W-1:0]   rd_data_a_i,
  input  logic [SGD_PC_W-1:0]   rd_data_b_i,
  output logic                  beat_o,
  output logic [SGD_PAIR_W-1:0] pair_o,
  output logic [SGD_PC_W-1:0]   opnd_a_o,
  output logic [SGD_PC_W-1:0]   opnd_b_o,
  output logic                  last_o,
  output logic [SGD_CFG_W-1:0]  cfg_o,
  output logic                  stall_o
);
  localparam int POS_W = SGD_CNT_W + 1;

  logic                  busy_q;
  logic [SGD_PAIR_W-1:0] pair_q;
  logic [SGD_CNT_W-1:0]  cnt_q;
  logic [SGD_REG_W-1:0]  regs_q [SGD_MAX_IN];
  logic [SGD_CFG_W-1:0]  cfg_q;

  logic [POS_W-1:0] pos_a, pos_b, cnt_x;
  logic [SGD_REG_W-1:0] sel_a, sel_b;
  logic live_a, live_b, last;

  always_comb begin
    pos_a = POS_W'(pair_q) << 1;
    pos_b = pos_a + 1'b1;
    cnt_x = POS_W'(cnt_q);
    live_a = pos_a < cnt_x;
    live_b = pos_b < cnt_x;
    last   = (pos_a + POS_W'(2)) >= cnt_x;
    sel_a = '0;
    sel_b = '0;
    for (int i = 0; i < SGD_MAX_IN; i++) begin
      if (pos_a == POS_W'(i)) sel_a = regs_q[i];
      if (pos_b == POS_W'(i)) sel_b = regs_q[i];
    end
  end

  assign rd_addr_a_o = live_a ? sel_a : '0;
  assign rd_addr_b_o = live_b ? sel_b : '0;
  assign opnd_a_o    = live_a ? rd_data_a_i : '0;
  assign opnd_b_o    = live_b ? rd_data_b_i : '0;
  assign beat_o      = busy_q;
  assign pair_o      = pair_q;
  assign last_o      = busy_q && last;
  assign cfg_o       = cfg_q;
  assign stall_o     = busy_q && !last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pair_q <= '0;
      cnt_q  <= '0;
      cfg_q  <= '0;
      for (int i = 0; i < SGD_MAX_IN; i++) regs_q[i] <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      pair_q <= '0;
      cnt_q  <= (cnt_i > SGD_CNT_W'(SGD_MAX_IN)) ? SGD_CNT_W'(SGD_MAX_IN) : cnt_i;
      cfg_q  <= cfg_i;
      for (int i = 0; i < SGD_MAX_IN; i++)
        regs_q[i] <= regs_i[i*SGD_REG_W +: SGD_REG_W];
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      pair_q <= pair_q + 1'b1;
    end
  end
endmodule

// File: rtl/subgraph_dispatch.sv
module subgraph_dispatch
  import sgd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fetch_valid_i,
  input  logic                  fetch_special_i,
  input  logic [SGD_PC_W-1:0]   fetch_pc_i,
  input  logic [SGD_PC_W-1:0]   fetch_tgt_i,
  output logic [SGD_PC_W-1:0]   next_pc_o,
  output logic                  redirect_o,
  output logic                  link_we_o,
  output logic [SGD_PC_W-1:0]   link_val_o,
  output logic                  stall_o,
  output logic [SGD_REG_W-1:0]  rd_addr_a_o,
  output logic [SGD_REG_W-1:0]  rd_addr_b_o,
  input  logic [SGD_PC_W-1:0]   rd_data_a_i,
  input  logic [SGD_PC_W-1:0]   rd_data_b_i,
  output logic                  opnd_valid_o,
  output logic [SGD_PAIR_W-1:0] opnd_pair_o,
  output logic [SGD_PC_W-1:0]   opnd_a_o,
  output logic [SGD_PC_W-1:0]   opnd_b_o,
  output logic                  opnd_last_o,
  output logic [SGD_CFG_W-1:0]  opnd_cfg_o,
  input  logic                  fill_en_i,
  input  logic [SGD_IDX_W-1:0]  fill_idx_i,
  input  logic                  fill_live_i,
  input  logic [SGD_TAG_W-1:0]  fill_tag_i,
  input  logic [SGD_PC_W-1:0]   fill_tgt_i,
  input  logic [SGD_CNT_W-1:0]  fill_cnt_i,
  input  logic [SGD_REGS_W-1:0] fill_regs_i,
  input  logic [SGD_CFG_W-1:0]  fill_cfg_i
);
  sgd_entry_t wr_entry, rd_entry;
  logic [SGD_IDX_W-1:0] look_idx;
  logic [SGD_TAG_W-1:0] look_tag;
  logic accept, hit, stall;
  logic unused_pc_lsb;

  assign unused_pc_lsb = ^fetch_pc_i[1:0];
  assign look_idx = fetch_pc_i[SGD_IDX_W+1:2];
  assign look_tag = fetch_pc_i[SGD_PC_W-1:SGD_IDX_W+2];

  assign wr_entry = '{live: fill_live_i, tag: fill_tag_i, tgt: fill_tgt_i,
                      cnt: fill_cnt_i, regs: fill_regs_i, cfg: fill_cfg_i};

  sgd_table u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (fill_en_i),
    .wr_idx_i   (fill_idx_i),
    .wr_entry_i (wr_entry),
    .rd_idx_i   (look_idx),
    .rd_entry_o (rd_entry)
  );

  // special opcodes only, and never while a gather holds fetch
  assign accept = fetch_valid_i && fetch_special_i && !stall;
  assign hit    = rd_entry.live && (rd_entry.tag == look_tag) && (rd_entry.tgt == fetch_tgt_i);

  sgd_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept && hit),
    .cnt_i       (rd_entry.cnt),
    .regs_i      (rd_entry.regs),
    .cfg_i       (rd_entry.cfg),
    .rd_addr_a_o (rd_addr_a_o),
    .rd_addr_b_o (rd_addr_b_o),
    .rd_data_a_i (rd_data_a_i),
    .rd_data_b_i (rd_data_b_i),
    .beat_o      (opnd_valid_o),
    .pair_o      (opnd_pair_o),
    .opnd_a_o    (opnd_a_o),
    .opnd_b_o    (opnd_b_o),
    .last_o      (opnd_last_o),
    .cfg_o       (opnd_cfg_o),
    .stall_o     (stall)
  );

  assign stall_o    = stall;
  assign redirect_o = accept && !hit;
  assign link_we_o  = accept && !hit;
  assign link_val_o = fetch_pc_i;

  always_comb begin
    if (stall)           next_pc_o = fetch_pc_i;
    else if (redirect_o) next_pc_o = fetch_tgt_i;
    else                 next_pc_o = fetch_pc_i + SGD_PC_W'(4);
  end
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
  import sgd_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fetch_valid_i,
  input logic                  fetch_special_i,
  input logic [SGD_PC_W-1:0]   fetch_tgt_i,
  input logic [SGD_PC_W-1:0]   next_pc_o,
  input logic                  redirect_o,
  input logic                  link_we_o,
  input logic                  stall_o,
  input logic                  opnd_valid_o,
  input logic                  opnd_last_o,
  input logic [SGD_PAIR_W-1:0] opnd_pair_o,
  input logic [SGD_CFG_W-1:0]  opnd_cfg_o
);
  p_miss_jumps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (link_we_o && next_pc_o == fetch_tgt_i));

  p_hit_starts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_special_i && !stall_o && !redirect_o)
      |=> (opnd_valid_o && opnd_pair_o == '0));

  p_plain_no_call_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !fetch_special_i) |-> (!redirect_o && !link_we_o));

  p_pair_steps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_valid_o && !opnd_last_o)
      |=> (opnd_valid_o && opnd_pair_o == $past(opnd_pair_o) + 2'd1));

  p_first_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_valid_o && !$past(opnd_valid_o)) |-> (opnd_pair_o == '0));

  p_cfg_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_valid_o && !opnd_last_o) |=> $stable(opnd_cfg_o));

  p_stall_in_beat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (opnd_valid_o && !opnd_last_o));

  p_stall_no_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !redirect_o);
endmodule

bind subgraph_dispatch sgd_checker u_sgd_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_valid_i   (fetch_valid_i),
  .fetch_special_i (fetch_special_i),
  .fetch_tgt_i     (fetch_tgt_i),
  .next_pc_o       (next_pc_o),
  .redirect_o      (redirect_o),
  .link_we_o       (link_we_o),
  .stall_o         (stall_o),
  .opnd_valid_o    (opnd_valid_o),
  .opnd_last_o     (opnd_last_o),
  .opnd_pair_o     (opnd_pair_o),
  .opnd_cfg_o      (opnd_cfg_o)
);

// File: tb/subgraph_dispatch_tb_top.sv
`timescale 1ns/1ps
module subgraph_dispatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        fetch_valid = 0, fetch_special = 0;
  logic [31:0] fetch_pc = 0, fetch_tgt = 0;
  logic [31:0] next_pc, link_val, rd_data_a, rd_data_b, opnd_a, opnd_b;
  logic        redirect, link_we, stall, opnd_valid, opnd_last;
  logic [4:0]  rd_addr_a, rd_addr_b;
  logic [1:0]  opnd_pair;
  logic [3:0]  opnd_cfg;
  logic        fill_en = 0, fill_live = 0;
  logic [3:0]  fill_idx = 0, fill_cfg = 0;
  logic [25:0] fill_tag = 0;
  logic [31:0] fill_tgt = 0;
  logic [2:0]  fill_cnt = 0;
  logic [29:0] fill_regs = 0;

  function automatic logic [31:0] rf(input logic [4:0] a);
    return 32'h5A00_0000 + {27'b0, a} * 32'h0001_0003;
  endfunction
  assign rd_data_a = rf(rd_addr_a);
  assign rd_data_b = rf(rd_addr_b);

  subgraph_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_special_i(fetch_special),
    .fetch_pc_i(fetch_pc), .fetch_tgt_i(fetch_tgt),
    .next_pc_o(next_pc), .redirect_o(redirect), .link_we_o(link_we),
    .link_val_o(link_val), .stall_o(stall),
    .rd_addr_a_o(rd_addr_a), .rd_addr_b_o(rd_addr_b),
    .rd_data_a_i(rd_data_a), .rd_data_b_i(rd_data_b),
    .opnd_valid_o(opnd_valid), .opnd_pair_o(opnd_pair),
    .opnd_a_o(opnd_a), .opnd_b_o(opnd_b), .opnd_last_o(opnd_last),
    .opnd_cfg_o(opnd_cfg),
    .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_live_i(fill_live),
    .fill_tag_i(fill_tag), .fill_tgt_i(fill_tgt), .fill_cnt_i(fill_cnt),
    .fill_regs_i(fill_regs), .fill_cfg_i(fill_cfg)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference table
  logic        m_live [16];
  logic [25:0] m_tag  [16];
  logic [31:0] m_tgt  [16];
  logic [2:0]  m_cnt  [16];
  logic [29:0] m_regs [16];
  logic [3:0]  m_cfg  [16];

  typedef struct {
    logic [1:0]  pair;
    logic [31:0] a, b;
    logic        last;
    logic [3:0]  cfg;
  } beat_t;
  beat_t exp_q[$];

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (opnd_valid) begin
        if (exp_q.size() == 0) begin
          chk("R5/R6", "unexpected beat", 32'(opnd_valid), 32'd0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk("R6", "pair", 32'(opnd_pair), 32'(e.pair));
          chk("R6", "lane a", opnd_a, e.a);
          chk("R6", "lane b", opnd_b, e.b);
          chk("R7", "last", 32'(opnd_last), 32'(e.last));
          chk("R7", "cfg", 32'(opnd_cfg), 32'(e.cfg));
          chk("R8", "stall in beat", 32'(stall), 32'(!e.last));
        end
      end else begin
        chk("R8", "stall idle", 32'(stall), 32'd0);
      end
    end
  end

  task automatic fill_drive(input logic [31:0] pc, input logic live, input logic [31:0] tgt,
                            input logic [2:0] cnt, input logic [29:0] regs, input logic [3:0] cfg);
    fill_en = 1; fill_idx = pc[5:2]; fill_tag = pc[31:6]; fill_live = live;
    fill_tgt = tgt; fill_cnt = cnt; fill_regs = regs; fill_cfg = cfg;
  endtask

  task automatic fill_end();
    m_live[fill_idx] = fill_live; m_tag[fill_idx] = fill_tag; m_tgt[fill_idx] = fill_tgt;
    m_cnt[fill_idx] = fill_cnt; m_regs[fill_idx] = fill_regs; m_cfg[fill_idx] = fill_cfg;
    fill_en = 0;
  endtask

  task automatic fill(input logic [31:0] pc, input logic live, input logic [31:0] tgt,
                      input logic [2:0] cnt, input logic [29:0] regs, input logic [3:0] cfg);
    fill_drive(pc, live, tgt, cnt, regs, cfg);
    @(posedge clk); #1;
    fill_end();
  endtask

  // driver: holds the instruction while stalled, pushes expected beats on a hit
  task automatic issue(input logic [31:0] pc, input logic [31:0] tgt, input logic sp);
    logic st, h;
    int ix, c, np;
    fetch_valid = 1; fetch_special = sp; fetch_pc = pc; fetch_tgt = tgt;
    do begin
      @(negedge clk);
      st = stall;
      if (!st) begin
        ix = pc[5:2];
        h = sp && m_live[ix] && (m_tag[ix] == pc[31:6]) && (m_tgt[ix] == tgt);  // R2
        if (!sp) begin
          chk("R5", "redirect", 32'(redirect), 32'd0);
          chk("R5", "link_we", 32'(link_we), 32'd0);
          chk("R5", "next_pc", next_pc, pc + 4);
        end else if (h) begin
          chk("R4", "redirect", 32'(redirect), 32'd0);
          chk("R4", "link_we", 32'(link_we), 32'd0);
          chk("R4", "next_pc", next_pc, pc + 4);
          c = (m_cnt[ix] > 6) ? 6 : int'(m_cnt[ix]);
          np = (c == 0) ? 1 : (c + 1) / 2;
          for (int k = 0; k < np; k++) begin
            beat_t b;
            b.pair = 2'(k);
            b.a = (2*k < c) ? rf(m_regs[ix][10*k +: 5]) : 32'd0;
            b.b = (2*k+1 < c) ? rf(m_regs[ix][10*k+5 +: 5]) : 32'd0;
            b.last = (k == np - 1);
            b.cfg = m_cfg[ix];
            exp_q.push_back(b);
          end
        end else begin
          chk("R3", "redirect", 32'(redirect), 32'd1);
          chk("R3", "link_we", 32'(link_we), 32'd1);
          chk("R3", "next_pc", next_pc, tgt);
          chk("R3", "link_val", link_val, pc);
        end
      end
      @(posedge clk); #1;
    end while (st);
    fetch_valid = 0; fetch_special = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (opnd_valid || exp_q.size() != 0);
    @(posedge clk); #1;
  endtask

  function automatic logic [29:0] pk(input int r0, r1, r2, r3, r4, r5);
    return {5'(r5), 5'(r4), 5'(r3), 5'(r2), 5'(r1), 5'(r0)};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam logic [31:0] PC_A = 32'h0000_1040;  // idx 0
  localparam logic [31:0] PC_B = 32'h0000_2044;  // idx 1
  localparam logic [31:0] PC_C = 32'h0000_3048;  // idx 2
  localparam logic [31:0] PC_D = 32'h0000_404C;  // idx 3
  localparam logic [31:0] PC_E = 32'h0000_5050;  // idx 4
  localparam logic [31:0] PC_F = 32'h0000_6054;  // idx 5
  localparam logic [31:0] PC_G = 32'h0000_7058;  // idx 6

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_live[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_cnt[i] = 0; m_regs[i] = 0; m_cfg[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1", "stall", 32'(stall), 32'd0);
    chk("R1", "opnd_valid", 32'(opnd_valid), 32'd0);
    @(posedge clk); #1;
    // R1/R3: empty table misses
    issue(PC_A, 32'h0000_8000, 1);

    // R4/R6/R8: six inputs, then a special call held behind the stall
    fill(PC_A, 1, 32'h0000_8000, 3'd6, pk(1, 2, 3, 4, 5, 6), 4'd9);
    issue(PC_A, 32'h0000_8000, 1);
    issue(PC_B, 32'h0000_9000, 1);  // R8: taken only after stall drops, misses
    wait_idle();

    // R6: odd count leaves lane b empty on the last beat
    fill(PC_B, 1, 32'h0000_9000, 3'd5, pk(7, 8, 9, 10, 11, 12), 4'd3);
    issue(PC_B, 32'h0000_9000, 1);
    issue(PC_B, 32'h0000_9000, 1);  // back-to-back hit
    wait_idle();

    // R6: counts 1, 0 and 7 (treated as 6)
    fill(PC_D, 1, 32'h0000_A000, 3'd1, pk(31, 30, 29, 28, 27, 26), 4'd1);
    fill(PC_E, 1, 32'h0000_B000, 3'd0, pk(13, 14, 15, 16, 17, 18), 4'd15);
    fill(PC_F, 1, 32'h0000_C000, 3'd7, pk(20, 21, 22, 23, 24, 25), 4'd6);
    issue(PC_D, 32'h0000_A000, 1);
    issue(PC_E, 32'h0000_B000, 1);
    issue(PC_F, 32'h0000_C000, 1);
    wait_idle();

    // R5: ordinary instruction at a mapped address
    issue(PC_A, 32'h0000_8000, 0);
    issue(PC_A + 4, 32'h0, 0);
    wait_idle();

    // R2: same index, other tag; same tag, other target
    issue(PC_A + 32'h40, 32'h0000_8000, 1);
    issue(PC_A, 32'h0000_8004, 1);
    wait_idle();

    // R9: fill and lookup of the same entry in one cycle
    fill_drive(PC_C, 1, 32'h0000_D000, 3'd2, pk(3, 17, 0, 0, 0, 0), 4'd12);
    issue(PC_C, 32'h0000_D000, 1);  // old contents: miss
    fill_end();
    issue(PC_C, 32'h0000_D000, 1);  // hit
    wait_idle();

    // R9: invalidate
    fill(PC_A, 0, 32'h0000_8000, 3'd6, pk(1, 2, 3, 4, 5, 6), 4'd9);
    issue(PC_A, 32'h0000_8000, 1);
    // R9: replace an entry
    fill(PC_G, 1, 32'h0000_E000, 3'd4, pk(9, 8, 7, 6, 0, 0), 4'd2);
    fill(PC_G, 1, 32'h0000_E000, 3'd3, pk(19, 18, 17, 0, 0, 0), 4'd5);
    issue(PC_G, 32'h0000_E000, 1);
    wait_idle();

    repeat (3) @(posedge clk);
    chk("R6", "queue drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule